// File: doc/BRIEF.md
# Paged Virtual Address Translator

This block turns a virtual address into a real address. It uses an on-chip table with one element per virtual page. Each memory request gives a virtual address and a read/write flag. The upper bits of the address select a table element. The element is checked for parity and for its usable flag. Within the same cycle the block returns either the real address, a paging fault request or a parity error.

A successful access marks the page as accessed. A successful write also marks it as written. A failed access leaves the element untouched. Software loads and stores whole elements through a separate maintenance port, one element per transfer. That port can set or clear any status flag, while the translation path only ever sets them.

Each element is 17 bits. Bit 16 is odd parity over bits 15..0. Bit 15 is the usable flag. Bit 14 is the accessed flag. Bit 13 is the written flag. Bits 12..0 hold the real page number. The virtual address is 21 bits: a 9-bit page index in bits 20..12 and a 12-bit byte offset in bits 11..0. The real address is the 13-bit real page number followed by the unchanged offset.

Top module: `vpage_xlat`

## Requirements
- R1: With `reqValid` high, sound parity and the usable flag (bit 15) set, `xlatOk` is high in the same cycle and `realAddr` equals {element bits 12..0, virtual bits 11..0}; `realAddr` is zero whenever `xlatOk` is low.
- R2: With sound parity and bit 15 clear, `pagingIrq` is high and `xlatOk` is low in the same cycle.
- R3: If the 17-bit element does not hold an odd number of ones, `parityErr` is high while `pagingIrq` and `xlatOk` stay low, regardless of the usable flag.
- R4: A successful write sets the written flag (bit 13) and the accessed flag (bit 14) of its element at the next clock edge, and it regenerates odd parity in bit 16.
- R5: A successful read sets the accessed flag (bit 14), leaves the written flag unchanged and regenerates odd parity.
- R6: A request that raises `pagingIrq` or `parityErr` leaves its element unchanged, bit for bit.
- R7: A maintenance load (`mntValid` and `mntWrite` high) stores `mntWdata` verbatim, parity bit included, at `mntIndex` at the clock edge. `mntRdata` always shows the full element at `mntIndex` without delay.
- R8: When a maintenance load and a status update hit the same element in the same cycle, the loaded value is kept. When they hit different elements, both take effect.
- R9: While `reqValid` is low or `rstN` is low, all three result outputs are low and no element changes through the translation path.
- R10: The translation path never clears a flag: a read of a page already marked written leaves the written flag set.
- R11: The byte offset reaches `realAddr` unchanged, from all-zero to all-one, for the lowest and highest page index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset; blocks translation and status updates |
| reqValid | input | 1 | A memory request is presented this cycle |
| reqWrite | input | 1 | 1 = write access, 0 = read access |
| reqVaddr | input | 21 | Virtual address: page index in bits 20..12, offset in bits 11..0 |
| xlatOk | output | 1 | Translation succeeded this cycle |
| realAddr | output | 25 | Real address: real page number then offset; zero unless `xlatOk` |
| pagingIrq | output | 1 | Paging-queue interrupt request: element not usable |
| parityErr | output | 1 | Parity mismatch on the looked-up element |
| mntValid | input | 1 | Maintenance transfer strobe |
| mntWrite | input | 1 | 1 = load element into table, 0 = store (read only) |
| mntIndex | input | 9 | Table element selected by the maintenance port |
| mntWdata | input | 17 | Element to load, parity bit included |
| mntRdata | output | 17 | Element currently held at `mntIndex` |

## Verification
The translation is exercised with reads and writes to usable pages whose flags start clear, and to pages already marked written. Those cases show that the flags are set and never cleared. Requests to non-usable pages and to elements loaded with broken parity show which fault outranks which. They also show that a failed access leaves the stored element exactly as loaded. Page indices 0 and 511 with all-zero and all-one offsets separate correct field placement from shifted or truncated concatenation. A maintenance load that lands on the element being translated in the same cycle, and one that lands on a different element, show that the two write paths keep the right priority and do not block each other.

// File: rtl/vpx_pkg.sv
package vpx_pkg;

  // Element layout: [16] odd parity, [15] usable, [14] accessed, [13] written, [12:0] real page
  localparam int DATA_BITS = 16;
  localparam int ELEM_BITS = DATA_BITS + 1;
  localparam int RPN_BITS  = 13;
  localparam int U_BIT     = 15;
  localparam int G_BIT     = 14;
  localparam int W_BIT     = 13;

  typedef struct packed {
    logic pass;   // translation granted this cycle
    logic updEn;  // write status update back to the looked-up element
    logic setW;   // status update also marks the page written
  } strb_t;

  function automatic logic oddPar(input logic [DATA_BITS-1:0] d);
    return ~^d;
  endfunction

endpackage

// File: rtl/vpx_ctrl.sv
module vpx_ctrl
  import vpx_pkg::*;
(
  input  logic  rstN,
  input  logic  reqValid,
  input  logic  reqWrite,
  input  logic  parOk,
  input  logic  usable,
  output logic  xlatOk,
  output logic  pagingIrq,
  output logic  parityErr,
  output strb_t strb
);

  logic active;
  logic grant;

  always_comb begin
    active    = rstN & reqValid;
    // parity is judged first: a corrupted usable flag cannot be trusted
    parityErr = active & ~parOk;
    pagingIrq = active & parOk & ~usable;
    grant     = active & parOk & usable;
    xlatOk    = grant;

    strb.pass  = grant;
    strb.updEn = grant;
    strb.setW  = grant & reqWrite;
  end

endmodule

// File: rtl/vpx_datapath.sv
module vpx_datapath
  import vpx_pkg::*;
#(
  parameter int PAGE_BITS = 9,
  parameter int OFFS_BITS = 12
) (
  input  logic                           clk,
  input  logic [PAGE_BITS-1:0]           reqPage,
  input  logic [OFFS_BITS-1:0]           reqOffs,
  input  strb_t                          strb,
  input  logic                           mntValid,
  input  logic                           mntWrite,
  input  logic [PAGE_BITS-1:0]           mntIndex,
  input  logic [ELEM_BITS-1:0]           mntWdata,
  output logic [ELEM_BITS-1:0]           mntRdata,
  output logic                           parOk,
  output logic                           usable,
  output logic [RPN_BITS+OFFS_BITS-1:0]  realAddr
);

  localparam int ENTRIES = 1 << PAGE_BITS;
  localparam int RA_BITS = RPN_BITS + OFFS_BITS;

  logic [ELEM_BITS-1:0] tbl [ENTRIES];

  logic [ELEM_BITS-1:0] elem;
  logic [DATA_BITS-1:0] elemData;
  logic [DATA_BITS-1:0] updData;
  logic                 mntLoad;

  always_comb begin
    elem     = tbl[reqPage];
    elemData = elem[DATA_BITS-1:0];
    parOk    = (^elem) == 1'b1;
    usable   = elemData[U_BIT];
    realAddr = strb.pass ? {elemData[RPN_BITS-1:0], reqOffs} : {RA_BITS{1'b0}};
    mntRdata = tbl[mntIndex];
    mntLoad  = mntValid & mntWrite;
  end

  // status flags are only ever raised on this path
  always_comb begin
    updData        = elemData;
    updData[G_BIT] = 1'b1;
    if (strb.setW) updData[W_BIT] = 1'b1;
  end

  // the maintenance load is applied last so it wins on a shared index
  always_ff @(posedge clk) begin
    if (strb.updEn) tbl[reqPage] <= {oddPar(updData), updData};
    if (mntLoad)    tbl[mntIndex] <= mntWdata;
  end

endmodule

// File: rtl/vpage_xlat.sv
module vpage_xlat
  import vpx_pkg::*;
#(
  parameter int PAGE_BITS = 9,
  parameter int OFFS_BITS = 12
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic                                   reqValid,
  input  logic                                   reqWrite,
  input  logic [PAGE_BITS+OFFS_BITS-1:0]         reqVaddr,
  output logic                                   xlatOk,
  output logic [vpx_pkg::RPN_BITS+OFFS_BITS-1:0] realAddr,
  output logic                                   pagingIrq,
  output logic                                   parityErr,
  input  logic                                   mntValid,
  input  logic                                   mntWrite,
  input  logic [PAGE_BITS-1:0]                   mntIndex,
  input  logic [vpx_pkg::ELEM_BITS-1:0]          mntWdata,
  output logic [vpx_pkg::ELEM_BITS-1:0]          mntRdata
);

  localparam int VA_BITS = PAGE_BITS + OFFS_BITS;

  strb_t strb;
  logic  parOk;
  logic  usable;

  vpx_ctrl i_ctrl (
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqWrite  (reqWrite),
    .parOk     (parOk),
    .usable    (usable),
    .xlatOk    (xlatOk),
    .pagingIrq (pagingIrq),
    .parityErr (parityErr),
    .strb      (strb)
  );

  vpx_datapath #(
    .PAGE_BITS (PAGE_BITS),
    .OFFS_BITS (OFFS_BITS)
  ) i_dp (
    .clk      (clk),
    .reqPage  (reqVaddr[VA_BITS-1:OFFS_BITS]),
    .reqOffs  (reqVaddr[OFFS_BITS-1:0]),
    .strb     (strb),
    .mntValid (mntValid),
    .mntWrite (mntWrite),
    .mntIndex (mntIndex),
    .mntWdata (mntWdata),
    .mntRdata (mntRdata),
    .parOk    (parOk),
    .usable   (usable),
    .realAddr (realAddr)
  );

endmodule

// File: rtl/vpx_checker.sv
module vpx_checker
  import vpx_pkg::*;
#(
  parameter int PAGE_BITS = 9,
  parameter int OFFS_BITS = 12
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          reqValid,
  input logic [PAGE_BITS+OFFS_BITS-1:0] reqVaddr,
  input logic                          xlatOk,
  input logic [RPN_BITS+OFFS_BITS-1:0] realAddr,
  input logic                          pagingIrq,
  input logic                          parityErr,
  input logic                          mntValid,
  input logic                          mntWrite,
  input logic [PAGE_BITS-1:0]          mntIndex,
  input logic [ELEM_BITS-1:0]          mntWdata,
  input logic [ELEM_BITS-1:0]          mntRdata,
  input logic                          updEn
);

  localparam int VA_BITS = PAGE_BITS + OFFS_BITS;

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({xlatOk, pagingIrq, parityErr})); // R3

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> !(xlatOk || pagingIrq || parityErr || updEn)); // R9

  AST_OFFSET_THROUGH: assert property (@(posedge clk) disable iff (!rstN)
    xlatOk |-> realAddr[OFFS_BITS-1:0] == reqVaddr[OFFS_BITS-1:0]); // R11

  AST_FAULT_NO_UPDATE: assert property (@(posedge clk) disable iff (!rstN)
    (pagingIrq || parityErr) |-> !updEn); // R6

  AST_LOAD_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    (mntValid && mntWrite) |=> (!$stable(mntIndex) || mntRdata == $past(mntWdata))); // R7

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (mntValid && mntWrite && xlatOk && mntIndex == reqVaddr[VA_BITS-1:OFFS_BITS])
    |=> (!$stable(mntIndex) || mntRdata == $past(mntWdata))); // R8

endmodule

bind vpage_xlat vpx_checker #(
  .PAGE_BITS (PAGE_BITS),
  .OFFS_BITS (OFFS_BITS)
) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqVaddr  (reqVaddr),
  .xlatOk    (xlatOk),
  .realAddr  (realAddr),
  .pagingIrq (pagingIrq),
  .parityErr (parityErr),
  .mntValid  (mntValid),
  .mntWrite  (mntWrite),
  .mntIndex  (mntIndex),
  .mntWdata  (mntWdata),
  .mntRdata  (mntRdata),
  .updEn     (strb.updEn)
);

// File: tb/test_vpage_xlat.sv
module test_vpage_xlat;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic        reqWrite;
  logic [20:0] reqVaddr;
  logic        xlatOk;
  logic [24:0] realAddr;
  logic        pagingIrq;
  logic        parityErr;
  logic        mntValid;
  logic        mntWrite;
  logic [8:0]  mntIndex;
  logic [16:0] mntWdata;
  logic [16:0] mntRdata;

  int applied = 0;
  int errs    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vpage_xlat i_vpage_xlat (
    .clk (clk), .rstN (rstN), .reqValid (reqValid), .reqWrite (reqWrite),
    .reqVaddr (reqVaddr), .xlatOk (xlatOk), .realAddr (realAddr),
    .pagingIrq (pagingIrq), .parityErr (parityErr), .mntValid (mntValid),
    .mntWrite (mntWrite), .mntIndex (mntIndex), .mntWdata (mntWdata),
    .mntRdata (mntRdata)
  );

  function automatic logic [16:0] mkElem(logic u, logic g, logic w, logic [12:0] rpn);
    logic [15:0] d;
    d = {u, g, w, rpn};
    return {~^d, d};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic load(logic [8:0] idx, logic [16:0] val);
    mntValid = 1'b1; mntWrite = 1'b1; mntIndex = idx; mntWdata = val;
    step();
    mntValid = 1'b0; mntWrite = 1'b0;
  endtask

  task automatic peek(string req, logic [8:0] idx, logic [16:0] exp);
    mntIndex = idx;
    #1;
    check(req, 32'(mntRdata), 32'(exp));
  endtask

  // present one request, check its same-cycle result, let the edge apply updates
  task automatic request(string req, logic wr, logic [8:0] pg, logic [11:0] off,
                         logic expOk, logic expIrq, logic expPar, logic [24:0] expRa);
    reqValid = 1'b1; reqWrite = wr; reqVaddr = {pg, off};
    #1;
    check({req, " ok"},  32'(xlatOk),    32'(expOk));
    check({req, " irq"}, 32'(pagingIrq), 32'(expIrq));
    check({req, " par"}, 32'(parityErr), 32'(expPar));
    check({req, " ra"},  32'(realAddr),  32'(expRa));
    step();
    reqValid = 1'b0;
  endtask

  task automatic tReset();
    rstN = 1'b0; reqValid = 1'b0; reqWrite = 1'b0; reqVaddr = '0;
    mntValid = 1'b0; mntWrite = 1'b0; mntIndex = '0; mntWdata = '0;
    step(); step();
    load(9'd20, mkElem(1'b1, 1'b0, 1'b0, 13'h0042));
    rstN = 1'b0;
    reqValid = 1'b1; reqWrite = 1'b1; reqVaddr = {9'd20, 12'h000};
    #1;
    check("R9 reset ok",  32'(xlatOk),    32'd0);
    check("R9 reset irq", 32'(pagingIrq), 32'd0);
    check("R9 reset par", 32'(parityErr), 32'd0);
    step();
    reqValid = 1'b0;
    peek("R9 reset no update", 9'd20, mkElem(1'b1, 1'b0, 1'b0, 13'h0042));
    rstN = 1'b1;
    step();
  endtask

  task automatic tLoadStore();
    load(9'd5, mkElem(1'b1, 1'b1, 1'b0, 13'h1234));
    peek("R7 load/store", 9'd5, mkElem(1'b1, 1'b1, 1'b0, 13'h1234));
    load(9'd6, 17'h0_0000 | 17'h0_8001);
    peek("R7 verbatim bad parity", 9'd6, 17'h0_8001);
  endtask

  task automatic tRead();
    load(9'd3, mkElem(1'b1, 1'b0, 1'b0, 13'h1ABC));
    request("R1 read", 1'b0, 9'd3, 12'h123, 1'b1, 1'b0, 1'b0, {13'h1ABC, 12'h123});
    peek("R5 read sets G only", 9'd3, mkElem(1'b1, 1'b1, 1'b0, 13'h1ABC));
  endtask

  task automatic tWrite();
    load(9'd7, mkElem(1'b1, 1'b0, 1'b0, 13'h0777));
    request("R4 write", 1'b1, 9'd7, 12'hABC, 1'b1, 1'b0, 1'b0, {13'h0777, 12'hABC});
    peek("R4 write sets W G", 9'd7, mkElem(1'b1, 1'b1, 1'b1, 13'h0777));
  endtask

  task automatic tNoClear();
    request("R10 read after write", 1'b0, 9'd7, 12'h001, 1'b1, 1'b0, 1'b0, {13'h0777, 12'h001});
    peek("R10 W kept", 9'd7, mkElem(1'b1, 1'b1, 1'b1, 13'h0777));
  endtask

  task automatic tUnusable();
    load(9'd9, mkElem(1'b0, 1'b0, 1'b0, 13'h0999));
    request("R2 unusable", 1'b1, 9'd9, 12'h010, 1'b0, 1'b1, 1'b0, 25'd0);
    peek("R6 unusable unchanged", 9'd9, mkElem(1'b0, 1'b0, 1'b0, 13'h0999));
  endtask

  task automatic tParity();
    logic [16:0] bad;
    bad = mkElem(1'b1, 1'b0, 1'b0, 13'h0BBB) ^ 17'h0_0004;
    load(9'd11, bad);
    request("R3 parity usable", 1'b1, 9'd11, 12'h020, 1'b0, 1'b0, 1'b1, 25'd0);
    peek("R6 parity unchanged", 9'd11, bad);
    bad = mkElem(1'b0, 1'b0, 1'b0, 13'h0CCC) ^ 17'h1_0000;
    load(9'd12, bad);
    request("R3 parity over U", 1'b0, 9'd12, 12'h030, 1'b0, 1'b0, 1'b1, 25'd0);
  endtask

  task automatic tCollide();
    load(9'd13, mkElem(1'b1, 1'b0, 1'b0, 13'h0013));
    mntValid = 1'b1; mntWrite = 1'b1; mntIndex = 9'd13;
    mntWdata = mkElem(1'b1, 1'b0, 1'b0, 13'h1313);
    request("R8 same entry", 1'b1, 9'd13, 12'h000, 1'b1, 1'b0, 1'b0, {13'h0013, 12'h000});
    mntValid = 1'b0; mntWrite = 1'b0;
    peek("R8 load wins", 9'd13, mkElem(1'b1, 1'b0, 1'b0, 13'h1313));
    load(9'd14, mkElem(1'b1, 1'b0, 1'b0, 13'h0014));
    mntValid = 1'b1; mntWrite = 1'b1; mntIndex = 9'd15;
    mntWdata = mkElem(1'b0, 1'b1, 1'b1, 13'h0015);
    request("R8 other entry", 1'b1, 9'd14, 12'h000, 1'b1, 1'b0, 1'b0, {13'h0014, 12'h000});
    mntValid = 1'b0; mntWrite = 1'b0;
    peek("R8 both: load", 9'd15, mkElem(1'b0, 1'b1, 1'b1, 13'h0015));
    peek("R8 both: update", 9'd14, mkElem(1'b1, 1'b1, 1'b1, 13'h0014));
  endtask

  task automatic tIdle();
    load(9'd16, mkElem(1'b1, 1'b0, 1'b0, 13'h0016));
    reqValid = 1'b0; reqWrite = 1'b1; reqVaddr = {9'd16, 12'h000};
    #1;
    check("R9 idle ok", 32'(xlatOk), 32'd0);
    check("R9 idle ra", 32'(realAddr), 32'd0);
    step();
    peek("R9 idle unchanged", 9'd16, mkElem(1'b1, 1'b0, 1'b0, 13'h0016));
  endtask

  task automatic tEdges();
    load(9'd0,   mkElem(1'b1, 1'b0, 1'b0, 13'h1FFF));
    load(9'd511, mkElem(1'b1, 1'b0, 1'b0, 13'h0001));
    request("R11 page0 offs ones", 1'b0, 9'd0, 12'hFFF, 1'b1, 1'b0, 1'b0, {13'h1FFF, 12'hFFF});
    request("R11 page0 offs zero", 1'b0, 9'd0, 12'h000, 1'b1, 1'b0, 1'b0, {13'h1FFF, 12'h000});
    request("R11 page511 offs ones", 1'b1, 9'd511, 12'hFFF, 1'b1, 1'b0, 1'b0, {13'h0001, 12'hFFF});
    request("R11 page511 offs zero", 1'b0, 9'd511, 12'h000, 1'b1, 1'b0, 1'b0, {13'h0001, 12'h000});
    peek("R4 page511 flags", 9'd511, mkElem(1'b1, 1'b1, 1'b1, 13'h0001));
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", applied, errs);
    $finish;
  end

  initial begin
    tReset();
    tLoadStore();
    tRead();
    tWrite();
    tNoClear();
    tUnusable();
    tParity();
    tCollide();
    tIdle();
    tEdges();
    $display("== %0d vectors applied, %0d miscompares ==", applied, errs);
    $finish;
  end

endmodule